// File: doc/BRIEF.md
# Gated Dual-Stream Frequency Counter

This block counts rising edges of a signal of unknown frequency, and it counts cycles of the local system clock. A gate input delivers one pulse per second from a satellite timing receiver. On each rising edge of that gate, both counts are latched in the same clock cycle. The edge counter is a chain of equal-width stages. Each stage steps only when every stage below it sits at its maximum, so the default of two 16-bit stages forms one 32-bit count. The high stage occupies the upper bits. The reference counter is a single 32-bit stage that steps on every clock.

Each stream keeps its own count of full-range wraps and its own gate sequence number. On a gate edge, a record holding {captured count, wrap count, sequence number} is placed on that stream's valid/ready output, for an external buffer to accept. Software further on divides the difference between consecutive edge counts by the elapsed reference cycles. The unknown input and the gate are both brought into the system clock domain through two-flop synchronisers. Both synchronisers idle at logic high, as a pulled-up pin would. Only rising edges are acted on, and the unknown input must stay below half the system clock frequency.

Top module: `gps_freq_counter`

## Requirements
- R1: The lowest stage of the edge counter steps once for each rising edge of `sig_in` seen after synchronisation, and wraps from all ones to zero.
- R2: Stage k+1 steps in the cycle that stage k wraps. The full count is the concatenation of the stages with the highest stage in the most significant bits, so with 4-bit stages a count of 25 reads 0x19.
- R3: A rising gate edge captures all stages of the edge count in one cycle. The captured value is the count before any increment in that cycle, and the record becomes valid on the following clock.
- R4: A wrap of the full edge count increments the stream's overflow count, which goes into each record. When a capture and a wrap fall in the same cycle, the record carries the count and the overflow count from before the increment.
- R5: The reference counter steps every clock and is captured on the same gate edge as the edge count. Its record carries the reference overflow count, with the same pre-increment rule on a coinciding wrap.
- R6: Each accepted gate edge raises each stream's sequence number by one. The first record after reset or clear carries 1.
- R7: A valid record holds its fields unchanged until `*_ready` is high at a clock edge. Acceptance clears valid unless a new capture arrives in that same cycle.
- R8: A capture while the previous record of that stream is valid and not being accepted sets that stream's sticky overrun flag. The new record replaces the old one. Only `rst` clears the overrun flag.
- R9: `clr` zeroes both counters, both overflow counts and both sequence numbers in the next cycle. A gate edge that coincides with `clr` produces no record.
- R10: Both synchronisers come out of reset at logic high. An input already high at reset release produces no edge, and falling edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters, overflow counts and sequence numbers |
| sig_in | input | 1 | Asynchronous signal of unknown frequency |
| gate_in | input | 1 | Asynchronous one-pulse-per-second gate |
| sig_valid | output | 1 | Edge-count record valid |
| sig_ready | input | 1 | Edge-count record accepted |
| sig_count | output | STAGE_W*STAGES | Captured edge count |
| sig_ovf | output | OVF_W | Edge-count overflow count |
| sig_seq | output | SEQ_W | Edge-count sequence number |
| sig_overrun | output | 1 | Sticky edge-stream overrun |
| ref_valid | output | 1 | Reference record valid |
| ref_ready | input | 1 | Reference record accepted |
| ref_count | output | REF_W | Captured reference count |
| ref_ovf | output | OVF_W | Reference overflow count |
| ref_seq | output | SEQ_W | Reference sequence number |
| ref_overrun | output | 1 | Sticky reference-stream overrun |

## Verification
The assertions check several local rules on every cycle:
- the step-by-one and hold rules of the stage chain;
- the overflow increment on a full wrap;
- zeroing after clear;
- single-cycle rise pulses;
- the holding of a valid record;
- the stickiness and setting of overrun.

Only the bench's scenarios show whether the captured values are right in absolute terms:
- that the captured value predates the same-cycle increment;
- that a gate edge during clear is dropped;
- that a high level at reset release counts nothing;
- that both streams latch at the same instant, including on a reference wrap hit exactly.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int FC_STAGE_W = 16;
    localparam int FC_STAGES  = 2;
    localparam int FC_REF_W   = 32;
    localparam int FC_OVF_W   = 16;
    localparam int FC_SEQ_W   = 32;

    // Logic level a synchroniser presents while the pin is undriven.
    typedef enum logic {
        IDLE_LOW  = 1'b0,
        IDLE_HIGH = 1'b1
    } idle_level_e;

    // Rising edge seen between two consecutive samples.
    function automatic logic fc_rise(input logic now_s, input logic prev_s);
        return now_s & ~prev_s;
    endfunction

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync
    import fc_pkg::*;
#(
    parameter idle_level_e IDLE = IDLE_HIGH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int DEPTH = 3;

    // [0] first flop, [1] second flop, [2] previous synchronised value
    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= {DEPTH{logic'(IDLE)}};
        else     shreg <= {shreg[DEPTH-2:0], din};
    end

    assign rise = fc_rise(shreg[1], shreg[2]);

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                               // R10

endmodule

// File: rtl/fc_cascade_counter.sv
module fc_cascade_counter #(
    parameter int STAGE_W = 16,
    parameter int STAGES  = 2,
    parameter int OVF_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        inc,
    output logic [STAGE_W*STAGES-1:0]   value,
    output logic [OVF_W-1:0]            ovf_cnt
);
    localparam int TOTAL_W = STAGE_W * STAGES;

    logic [STAGES:0] carry;
    assign carry[0] = inc;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [STAGE_W-1:0] q;
        assign carry[g+1] = carry[g] & (&q);
        assign value[g*STAGE_W +: STAGE_W] = q;
        always_ff @(posedge clk) begin
            if (rst || clr)    q <= '0;
            else if (carry[g]) q <= q + STAGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)          ovf_cnt <= '0;
        else if (carry[STAGES])  ovf_cnt <= ovf_cnt + OVF_W'(1);
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> value == $past(value) + TOTAL_W'(1));        // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(value) && $stable(ovf_cnt));        // R1
    AST_WRAP_OVF: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && (&value)) |=> ovf_cnt == $past(ovf_cnt) + OVF_W'(1)); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0) && (ovf_cnt == '0));                     // R9

endmodule

// File: rtl/fc_record_port.sv
module fc_record_port #(
    parameter int CNT_W = 32,
    parameter int OVF_W = 16,
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             capture,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [OVF_W-1:0] ovf_in,
    output logic             valid,
    input  logic             ready,
    output logic [CNT_W-1:0] rec_cnt,
    output logic [OVF_W-1:0] rec_ovf,
    output logic [SEQ_W-1:0] rec_seq,
    output logic             overrun
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OVF_W-1:0] ovf;
        logic [SEQ_W-1:0] seq;
    } rec_t;

    rec_t             rec_q;
    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] seq_next;

    assign seq_next = seq_q + SEQ_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)   seq_q <= '0;
        else if (capture) seq_q <= seq_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            rec_q   <= '0;
            overrun <= 1'b0;
        end else if (capture) begin
            valid   <= 1'b1;
            rec_q   <= '{cnt: cnt_in, ovf: ovf_in, seq: seq_next};
            overrun <= overrun | (valid & ~ready);
        end else if (ready) begin
            valid   <= 1'b0;
        end
    end

    assign rec_cnt = rec_q.cnt;
    assign rec_ovf = rec_q.ovf;
    assign rec_seq = rec_q.seq;

    AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (rst)
        capture |=> valid);                                            // R7
    AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !capture) |=> valid && $stable(rec_cnt)
            && $stable(rec_ovf) && $stable(rec_seq));                  // R7
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (capture && valid && !ready) |=> overrun);                     // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);                                          // R8

endmodule

// File: rtl/gps_freq_counter.sv
module gps_freq_counter
    import fc_pkg::*;
#(
    parameter int STAGE_W = FC_STAGE_W,
    parameter int STAGES  = FC_STAGES,
    parameter int REF_W   = FC_REF_W,
    parameter int OVF_W   = FC_OVF_W,
    parameter int SEQ_W   = FC_SEQ_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       sig_in,
    input  logic                       gate_in,
    output logic                       sig_valid,
    input  logic                       sig_ready,
    output logic [STAGE_W*STAGES-1:0]  sig_count,
    output logic [OVF_W-1:0]           sig_ovf,
    output logic [SEQ_W-1:0]           sig_seq,
    output logic                       sig_overrun,
    output logic                       ref_valid,
    input  logic                       ref_ready,
    output logic [REF_W-1:0]           ref_count,
    output logic [OVF_W-1:0]           ref_ovf,
    output logic [SEQ_W-1:0]           ref_seq,
    output logic                       ref_overrun
);
    localparam int SIG_W = STAGE_W * STAGES;

    logic             sig_rise, gate_rise, capture;
    logic [SIG_W-1:0] sig_live;
    logic [OVF_W-1:0] sig_live_ovf;
    logic [REF_W-1:0] ref_live;
    logic [OVF_W-1:0] ref_live_ovf;

    fc_edge_sync #(.IDLE(IDLE_HIGH)) u_sig_sync (
        .clk(clk), .rst(rst), .din(sig_in), .rise(sig_rise)
    );
    fc_edge_sync #(.IDLE(IDLE_HIGH)) u_gate_sync (
        .clk(clk), .rst(rst), .din(gate_in), .rise(gate_rise)
    );

    // clear outranks a coinciding gate edge
    assign capture = gate_rise & ~clr;

    fc_cascade_counter #(.STAGE_W(STAGE_W), .STAGES(STAGES), .OVF_W(OVF_W)) u_sig_cnt (
        .clk(clk), .rst(rst), .clr(clr), .inc(sig_rise),
        .value(sig_live), .ovf_cnt(sig_live_ovf)
    );
    fc_cascade_counter #(.STAGE_W(REF_W), .STAGES(1), .OVF_W(OVF_W)) u_ref_cnt (
        .clk(clk), .rst(rst), .clr(clr), .inc(1'b1),
        .value(ref_live), .ovf_cnt(ref_live_ovf)
    );

    fc_record_port #(.CNT_W(SIG_W), .OVF_W(OVF_W), .SEQ_W(SEQ_W)) u_sig_port (
        .clk(clk), .rst(rst), .clr(clr), .capture(capture),
        .cnt_in(sig_live), .ovf_in(sig_live_ovf),
        .valid(sig_valid), .ready(sig_ready),
        .rec_cnt(sig_count), .rec_ovf(sig_ovf), .rec_seq(sig_seq),
        .overrun(sig_overrun)
    );
    fc_record_port #(.CNT_W(REF_W), .OVF_W(OVF_W), .SEQ_W(SEQ_W)) u_ref_port (
        .clk(clk), .rst(rst), .clr(clr), .capture(capture),
        .cnt_in(ref_live), .ovf_in(ref_live_ovf),
        .valid(ref_valid), .ready(ref_ready),
        .rec_cnt(ref_count), .rec_ovf(ref_ovf), .rec_seq(ref_seq),
        .overrun(ref_overrun)
    );

    AST_STREAMS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (capture) |=> sig_valid && ref_valid && (sig_seq == ref_seq)); // R5

endmodule

// File: tb/gps_freq_counter_tb.sv
module gps_freq_counter_tb;
    localparam int SW = 4, NS = 2, RW = 10, OW = 4, QW = 8;
    localparam int CW = SW * NS;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [RW-1:0] RMAX = '1;

    logic clk = 0, rst = 1, clr = 0, sig_in = 1, gate_in = 1;
    logic sig_ready = 0, ref_ready = 0;
    logic sig_valid, ref_valid, sig_overrun, ref_overrun;
    logic [CW-1:0] sig_count;
    logic [RW-1:0] ref_count;
    logic [OW-1:0] sig_ovf, ref_ovf;
    logic [QW-1:0] sig_seq, ref_seq;

    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gps_freq_counter #(.STAGE_W(SW), .STAGES(NS), .REF_W(RW), .OVF_W(OW), .SEQ_W(QW)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .sig_in(sig_in), .gate_in(gate_in),
        .sig_valid(sig_valid), .sig_ready(sig_ready), .sig_count(sig_count),
        .sig_ovf(sig_ovf), .sig_seq(sig_seq), .sig_overrun(sig_overrun),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_count(ref_count),
        .ref_ovf(ref_ovf), .ref_seq(ref_seq), .ref_overrun(ref_overrun)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic hs1, hs2, hs3, hg1, hg2, hg3;
    logic [CW-1:0] m_cnt;  logic [OW-1:0] m_ovf;  logic [QW-1:0] m_seq;
    logic [RW-1:0] m_ref;  logic [OW-1:0] m_rovf;
    logic ms_v, mr_v, ms_o, mr_o;
    logic [CW-1:0] ms_cnt; logic [OW-1:0] ms_ovf; logic [QW-1:0] ms_seq;
    logic [RW-1:0] mr_cnt; logic [OW-1:0] mr_ovf; logic [QW-1:0] mr_seq;

    always @(posedge clk) begin
        if (rst) begin
            {hs1, hs2, hs3, hg1, hg2, hg3} = 6'b111111;
            m_cnt = 0; m_ovf = 0; m_seq = 0; m_ref = 0; m_rovf = 0;
            ms_v = 0; mr_v = 0; ms_o = 0; mr_o = 0;
            ms_cnt = 0; ms_ovf = 0; ms_seq = 0; mr_cnt = 0; mr_ovf = 0; mr_seq = 0;
        end else begin
            logic srise, grise, cap;
            srise = hs2 && !hs3;
            grise = hg2 && !hg3;
            hs3 = hs2; hs2 = hs1; hs1 = sig_in;
            hg3 = hg2; hg2 = hg1; hg1 = gate_in;
            cap = grise && !clr;
            if (cap) begin
                m_seq = m_seq + 1;
                if (ms_v && !sig_ready) ms_o = 1;
                if (mr_v && !ref_ready) mr_o = 1;
                ms_v = 1; ms_cnt = m_cnt; ms_ovf = m_ovf; ms_seq = m_seq;
                mr_v = 1; mr_cnt = m_ref; mr_ovf = m_rovf; mr_seq = m_seq;
            end else begin
                if (sig_ready) ms_v = 0;
                if (ref_ready) mr_v = 0;
            end
            if (clr) begin
                m_cnt = 0; m_ovf = 0; m_seq = 0; m_ref = 0; m_rovf = 0;
            end else begin
                if (srise) begin
                    if (m_cnt == CMAX) m_ovf = m_ovf + 1;
                    m_cnt = m_cnt + 1;
                end
                if (m_ref == RMAX) m_rovf = m_rovf + 1;
                m_ref = m_ref + 1;
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 sig valid", sig_valid, ms_v);
            chk("R7 ref valid", ref_valid, mr_v);
            chk("R8 sig overrun", sig_overrun, ms_o);
            chk("R8 ref overrun", ref_overrun, mr_o);
            if (ms_v) begin
                chk("R3 sig count", sig_count, ms_cnt);
                chk("R4 sig ovf", sig_ovf, ms_ovf);
                chk("R6 sig seq", sig_seq, ms_seq);
            end
            if (mr_v) begin
                chk("R5 ref count", ref_count, mr_cnt);
                chk("R5 ref ovf", ref_ovf, mr_ovf);
                chk("R6 ref seq", ref_seq, mr_seq);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_sig(input int n);
        for (int i = 0; i < n; i++) begin
            sig_in = 1; @(negedge clk);
            sig_in = 0; @(negedge clk);
        end
    endtask

    task automatic pulse_gate();
        gate_in = 1; @(negedge clk);
        gate_in = 0; @(negedge clk);
    endtask

    task automatic wait_rec();
        while (!(sig_valid && ref_valid)) @(negedge clk);
    endtask

    task automatic ack();
        sig_ready = 1; ref_ready = 1; @(negedge clk);
        sig_ready = 0; ref_ready = 0;
    endtask

    initial begin
        logic [OW-1:0] rovf_before;
        // R10: inputs held high through reset release
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (8) @(negedge clk);
        chk("R10 no record from high level at reset release", sig_valid, 0);
        sig_in = 0; gate_in = 0;
        repeat (6) @(negedge clk);
        chk("R10 falling edges produce nothing", ref_valid, 0);

        // R1 / R6: first gated record
        pulse_sig(5); pulse_gate(); wait_rec();
        chk("R1 five edges counted", sig_count, 5);
        chk("R6 first sequence number", sig_seq, 1);
        ack();

        // R2: carry into upper stage
        pulse_sig(20); pulse_gate(); wait_rec();
        chk("R2 cascaded count", sig_count, 25);
        chk("R2 upper stage", sig_count[CW-1:SW], 1);
        ack();

        // R7 / R8: two gates with no acceptance
        pulse_gate(); repeat (6) @(negedge clk);
        pulse_gate(); repeat (6) @(negedge clk);
        chk("R8 overrun set", sig_overrun, 1);
        chk("R8 newest record kept", sig_seq, 4);
        chk("R7 record still valid", sig_valid, 1);
        ack(); repeat (4) @(negedge clk);
        chk("R8 overrun sticky", ref_overrun, 1);

        // R9: gate edge coinciding with clear is dropped
        gate_in = 1; @(negedge clk);
        gate_in = 0; @(negedge clk);
        clr = 1; @(negedge clk);
        clr = 0;
        repeat (8) @(negedge clk);
        chk("R9 gate during clear ignored", sig_valid, 0);
        pulse_sig(3); pulse_gate(); wait_rec();
        chk("R9 count restarted", sig_count, 3);
        chk("R9 sequence restarted", ref_seq, 1);
        ack();

        // R4: wrap and capture in the same cycle
        clr = 1; @(negedge clk); clr = 0;
        pulse_sig(255);
        sig_in = 1; gate_in = 1; @(negedge clk);
        sig_in = 0; gate_in = 0; @(negedge clk);
        wait_rec();
        chk("R4 pre-increment count", sig_count, 255);
        chk("R4 pre-increment ovf", sig_ovf, 0);
        ack();
        pulse_sig(2); pulse_gate(); wait_rec();
        chk("R4 ovf after wrap", sig_ovf, 1);
        chk("R4 count after wrap", sig_count, 2);
        ack();

        // fast input: an edge every second cycle with gates in between
        for (int k = 0; k < 300; k++) begin
            sig_in = ~sig_in;
            if (k == 100 || k == 200) gate_in = 1;
            if (k == 101 || k == 201) gate_in = 0;
            if (k == 150 || k == 250) begin sig_ready = 1; ref_ready = 1; end
            if (k == 151 || k == 251) begin sig_ready = 0; ref_ready = 0; end
            @(negedge clk);
        end
        sig_in = 0; repeat (4) @(negedge clk);
        ack();

        // R5: gate lands exactly on the reference wrap
        while (m_ref != RMAX - 2) @(negedge clk);
        rovf_before = m_rovf;
        pulse_gate(); wait_rec();
        chk("R5 ref count at wrap", ref_count, RMAX);
        chk("R5 ref ovf pre-increment", ref_ovf, rovf_before);
        ack();
        repeat (20) @(negedge clk);
        pulse_gate(); wait_rec();
        chk("R5 ref ovf advanced", ref_ovf, rovf_before + 1'b1);
        ack();

        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule